// File: doc/BRIEF.md
# Chained Vector Pipeline Timing Unit

This block is the timing model and controller for a vector SAXPY sequence (Y = a*X + Y) run on three kinds of functional unit. It tracks per-element tokens instead of real data. The steps are: read X, scale by a scalar, read Y, add, and write Y back. The memory read pipe and the memory write pipe each take 12 cycles before their first result. The multiplier takes 7 cycles and the adder takes 6. After that start-up, each pipe returns one element per cycle.

A start pulse captures two things: a vector length and a mode bit. In convoy mode, each group of operations waits until the previous group has produced its last result. In chained mode, a dependent unit may take element k as soon as its producer has written that element. For every unit, the block emits an issue strobe with the element index and a completion strobe. When the final element has been written back, it reports the total cycle count.

Cycle numbering starts at 0 in the first cycle after the accepted start edge. The reported count is the cycle number in which the write pipe completes the last element.

Top module: `vpt_chain_timer`

## Requirements
- R1: After reset, busy_o, done_o, cycles_o and every issue and completion strobe are 0. While the block is idle, no issue strobe is raised.
- R2: Each completion strobe fires exactly its unit's latency after the matching issue: 12 for the read pipe and the write pipe, 7 for the multiplier and 6 for the adder. A unit issues at most one element per cycle, in index order.
- R3: In convoy mode (chain_i = 0) with length n from 1 to 8, cycles_o reads 42+4n when done_o pulses.
- R4: In convoy mode, the first issue cycles are fixed. The multiplier's first issue is at cycle 12+n and the first Y read is at 13+n. The adder's first issue is at 25+2n and the write pipe's first issue is at 31+3n. X reads issue at cycles 0 to n-1.
- R5: In chained mode (chain_i = 1), element k follows these rules:
  - Its multiply issues the cycle after its X read completes, which is cycle 13+k.
  - Its Y read issues at cycle n+k.
  - Its add issues the cycle after both its product and its Y element are ready.
  - Its write issues the cycle after its sum is ready.
  - The total is max(20, 12+n)+n+19.
- R6: For every length from 1 to 8, the chained count is strictly smaller than the convoy count.
- R7: A length of 0 raises done_o in cycle 0 with cycles_o = 0. No unit issues anything.
- R8: A length above 8 is treated as 8.
- R9: A start pulse that arrives while busy_o is 1 is ignored. The run in progress finishes with its own count, and no second run follows.
- R10: The read pipe never issues an X element and a Y element in the same cycle. ld_y_o = 1 marks a Y read and ld_y_o = 0 marks an X read.
- R11: Mode and length are captured only at an accepted start. Changing chain_i or vlen_i during a run does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| chain_i | input | 1 | 1 = element-level chaining, 0 = convoy mode |
| vlen_i | input | 4 | Vector length; values above 8 are treated as 8 |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse; cycles_o is valid from this cycle |
| cycles_o | output | 8 | Cycle in which the last element was written |
| ld_issue_o | output | 1 | Read pipe issues an element |
| ld_y_o | output | 1 | The issued read is of Y (0 means X) |
| ld_idx_o | output | 3 | Element index of the read |
| ld_done_o | output | 1 | Read pipe returns an element |
| mul_issue_o | output | 1 | Multiplier issues an element |
| mul_idx_o | output | 3 | Element index for the multiplier |
| mul_done_o | output | 1 | Multiplier returns a product |
| add_issue_o | output | 1 | Adder issues an element |
| add_idx_o | output | 3 | Element index for the adder |
| add_done_o | output | 1 | Adder returns a sum |
| st_issue_o | output | 1 | Write pipe issues an element |
| st_idx_o | output | 3 | Element index of the write |
| st_done_o | output | 1 | Write pipe completes an element |

## Verification
Some rules are checked on every cycle by the embedded properties:
- No consumer issues an element whose operands are not yet marked ready.
- The read pipe never takes two elements in one cycle.
- The idle block stays silent.
- Every convoy-mode total equals 42+4n, and every chained total is below that figure.

Other behaviour is visible only through the bench's scenarios:
- The exact first-issue cycles of each convoy and the per-unit latency gaps.
- That chaining starts the Y read right behind X.
- The handling of zero and oversized lengths.
- That a start pulse or an input change during a run has no effect.

// File: rtl/vpt_pkg.sv
// Package: shared latencies, sizes and the controller state type.
// Assumes all latencies are at least 1 and the read latency is no smaller
// than the multiply latency (this sets the convoy-mode total formula).
package vpt_pkg;
    localparam int MEM_LAT  = 12;
    localparam int MUL_LAT  = 7;
    localparam int ADD_LAT  = 6;
    localparam int MAX_VL   = 8;
    localparam int CNT_W    = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/vpt_unit_pipe.sv
// Module: fixed-latency functional unit model. A token (valid + tag) that
// enters in cycle c leaves as a completion strobe in cycle c+LAT.
// Assumes at most one token enters per cycle; the pipe never stalls.
module vpt_unit_pipe #(
    parameter int LAT = 4,
    parameter int TW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [TW-1:0] in_tag,
    output logic          out_vld,
    output logic [TW-1:0] out_tag
);
    logic [LAT-1:0] vld_q;
    logic [TW-1:0]  tag_q [LAT];

    // First stage captures the issued token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            tag_q[0] <= '0;
        end else begin
            vld_q[0] <= in_vld;
            tag_q[0] <= in_tag;
        end
    end

    // Remaining stages shift the token one step per cycle.
    for (genvar j = 1; j < LAT; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[j] <= 1'b0;
                tag_q[j] <= '0;
            end else begin
                vld_q[j] <= vld_q[j-1];
                tag_q[j] <= tag_q[j-1];
            end
        end
    end

    assign out_vld = vld_q[LAT-1];
    assign out_tag = tag_q[LAT-1];
endmodule

// File: rtl/vpt_scoreboard.sv
// Module: per-element ready flags for one vector register. A completion
// sets its element's flag; the flag is visible one cycle later.
// Assumes clr is raised only at an accepted start.
module vpt_scoreboard #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set,
    input  logic [IW-1:0] set_idx,
    output logic [N-1:0]  flags
);
    // Clear on reset or start; otherwise mark the completed element ready.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
        end else if (set) begin
            flags[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/vpt_issue_seq.sv
// Module: in-order issue sequencer for one consumer. It issues element cnt
// when the run is active, the gate is open, the element lies within the
// vector and its operands are flagged ready.
// Assumes vlen does not exceed N.
module vpt_issue_seq #(
    parameter int N  = 8,
    parameter int LW = 4,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [LW-1:0] vlen,
    input  logic [N-1:0]  src_ok,
    input  logic          gate,
    output logic          issue_o,
    output logic [IW-1:0] idx_o
);
    logic [LW-1:0] cnt_q;

    // Issue decision for the current element.
    always_comb begin
        idx_o   = cnt_q[IW-1:0];
        issue_o = run && gate && (cnt_q < vlen) && src_ok[idx_o];
    end

    // Advance to the next element after each issue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (issue_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vpt_chain_timer.sv
// Module: top of the chained vector pipeline timing unit. It sequences the
// SAXPY token flow (read X, multiply, read Y, add, write Y) in either convoy
// or chained mode and reports the completion cycle of the last write.
// Assumes one read pipe shared by X and Y and a separate write pipe.
module vpt_chain_timer
    import vpt_pkg::*;
#(
    parameter int MAX_LEN = MAX_VL,
    parameter int LD_LAT  = MEM_LAT,
    parameter int ML_LAT  = MUL_LAT,
    parameter int AD_LAT  = ADD_LAT,
    parameter int CW      = CNT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          chain_i,
    input  logic [$clog2(MAX_LEN+1)-1:0]  vlen_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [CW-1:0]                 cycles_o,
    output logic                          ld_issue_o,
    output logic                          ld_y_o,
    output logic [$clog2(MAX_LEN)-1:0]    ld_idx_o,
    output logic                          ld_done_o,
    output logic                          mul_issue_o,
    output logic [$clog2(MAX_LEN)-1:0]    mul_idx_o,
    output logic                          mul_done_o,
    output logic                          add_issue_o,
    output logic [$clog2(MAX_LEN)-1:0]    add_idx_o,
    output logic                          add_done_o,
    output logic                          st_issue_o,
    output logic [$clog2(MAX_LEN)-1:0]    st_idx_o,
    output logic                          st_done_o
);
    localparam int LW = $clog2(MAX_LEN + 1);
    localparam int IW = $clog2(MAX_LEN);
    localparam int CONVOY_BASE = 3 * LD_LAT + AD_LAT;

    run_state_t    state_q;
    logic          chain_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] vlen_eff;
    logic [CW-1:0] cyc_q;
    logic [CW-1:0] cycles_q;
    logic          done_q;
    logic          accept;
    logic          run;
    logic [MAX_LEN-1:0] mask;
    logic [MAX_LEN-1:0] xrdy, yrdy, mrdy, ardy;
    logic [MAX_LEN-1:0] all_ones;
    logic          x_all, y_all, m_all, a_all;
    logic          x_fin_q, mul_started_q;

    logic          ldx_issue, ldy_issue, mul_issue, add_issue, st_issue;
    logic [IW-1:0] ldx_idx, ldy_idx, mul_idx, add_idx, st_idx;
    logic          ld_out_vld, mul_out_vld, add_out_vld, st_out_vld;
    logic [IW:0]   ld_out_tag;
    logic [IW-1:0] mul_out_tag, add_out_tag, st_out_tag;
    logic          last_write;

    // Clamp the requested length to the supported maximum.
    always_comb begin
        vlen_eff = (vlen_i > LW'(MAX_LEN)) ? LW'(MAX_LEN) : vlen_i;
        accept   = start_i && (state_q == ST_IDLE);
        run      = (state_q == ST_RUN);
        all_ones = '1;
    end

    // Element mask of the captured length and "whole vector ready" flags.
    always_comb begin
        for (int k = 0; k < MAX_LEN; k++) begin
            mask[k] = (k < int'(len_q));
        end
        x_all = &(xrdy | ~mask);
        y_all = &(yrdy | ~mask);
        m_all = &(mrdy | ~mask);
        a_all = &(ardy | ~mask);
    end

    // Run control: capture mode and length, count cycles, latch the total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            chain_q  <= 1'b0;
            len_q    <= '0;
            cyc_q    <= '0;
            cycles_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                chain_q <= chain_i;
                len_q   <= vlen_eff;
                cyc_q   <= '0;
                if (vlen_eff == '0) begin
                    cycles_q <= '0;
                    done_q   <= 1'b1;
                end else begin
                    state_q <= ST_RUN;
                end
            end else if (run) begin
                cyc_q <= cyc_q + 1'b1;
                if (last_write) begin
                    cycles_q <= cyc_q;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
            end
        end
    end

    // Progress flags: all X reads issued, multiplier has begun.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            x_fin_q       <= 1'b0;
            mul_started_q <= 1'b0;
        end else begin
            if (ldx_issue && (ldx_idx == IW'(len_q - 1'b1))) x_fin_q <= 1'b1;
            if (mul_issue) mul_started_q <= 1'b1;
        end
    end

    // X reads need no operands and start at once.
    vpt_issue_seq #(.N(MAX_LEN), .LW(LW), .IW(IW)) u_seq_ldx (
        .clk(clk), .rst_n(rst_n), .clr(accept), .run(run), .vlen(len_q),
        .src_ok(all_ones), .gate(1'b1),
        .issue_o(ldx_issue), .idx_o(ldx_idx)
    );

    // Y reads follow X when chained, or trail the multiplier in convoy mode.
    vpt_issue_seq #(.N(MAX_LEN), .LW(LW), .IW(IW)) u_seq_ldy (
        .clk(clk), .rst_n(rst_n), .clr(accept), .run(run), .vlen(len_q),
        .src_ok(all_ones), .gate(chain_q ? x_fin_q : mul_started_q),
        .issue_o(ldy_issue), .idx_o(ldy_idx)
    );

    vpt_issue_seq #(.N(MAX_LEN), .LW(LW), .IW(IW)) u_seq_mul (
        .clk(clk), .rst_n(rst_n), .clr(accept), .run(run), .vlen(len_q),
        .src_ok(xrdy), .gate(chain_q || x_all),
        .issue_o(mul_issue), .idx_o(mul_idx)
    );

    vpt_issue_seq #(.N(MAX_LEN), .LW(LW), .IW(IW)) u_seq_add (
        .clk(clk), .rst_n(rst_n), .clr(accept), .run(run), .vlen(len_q),
        .src_ok(mrdy & yrdy), .gate(chain_q || (m_all && y_all)),
        .issue_o(add_issue), .idx_o(add_idx)
    );

    vpt_issue_seq #(.N(MAX_LEN), .LW(LW), .IW(IW)) u_seq_st (
        .clk(clk), .rst_n(rst_n), .clr(accept), .run(run), .vlen(len_q),
        .src_ok(ardy), .gate(chain_q || a_all),
        .issue_o(st_issue), .idx_o(st_idx)
    );

    // Functional unit pipes; the read pipe tag carries the X/Y selector.
    vpt_unit_pipe #(.LAT(LD_LAT), .TW(IW + 1)) u_pipe_ld (
        .clk(clk), .rst_n(rst_n), .in_vld(ldx_issue || ldy_issue),
        .in_tag({ldy_issue, ldy_issue ? ldy_idx : ldx_idx}),
        .out_vld(ld_out_vld), .out_tag(ld_out_tag)
    );

    vpt_unit_pipe #(.LAT(ML_LAT), .TW(IW)) u_pipe_mul (
        .clk(clk), .rst_n(rst_n), .in_vld(mul_issue), .in_tag(mul_idx),
        .out_vld(mul_out_vld), .out_tag(mul_out_tag)
    );

    vpt_unit_pipe #(.LAT(AD_LAT), .TW(IW)) u_pipe_add (
        .clk(clk), .rst_n(rst_n), .in_vld(add_issue), .in_tag(add_idx),
        .out_vld(add_out_vld), .out_tag(add_out_tag)
    );

    vpt_unit_pipe #(.LAT(LD_LAT), .TW(IW)) u_pipe_st (
        .clk(clk), .rst_n(rst_n), .in_vld(st_issue), .in_tag(st_idx),
        .out_vld(st_out_vld), .out_tag(st_out_tag)
    );

    // Element-ready scoreboards for X, Y, products and sums.
    vpt_scoreboard #(.N(MAX_LEN), .IW(IW)) u_sb_x (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .set(ld_out_vld && !ld_out_tag[IW]), .set_idx(ld_out_tag[IW-1:0]),
        .flags(xrdy)
    );

    vpt_scoreboard #(.N(MAX_LEN), .IW(IW)) u_sb_y (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .set(ld_out_vld && ld_out_tag[IW]), .set_idx(ld_out_tag[IW-1:0]),
        .flags(yrdy)
    );

    vpt_scoreboard #(.N(MAX_LEN), .IW(IW)) u_sb_m (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .set(mul_out_vld), .set_idx(mul_out_tag), .flags(mrdy)
    );

    vpt_scoreboard #(.N(MAX_LEN), .IW(IW)) u_sb_a (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .set(add_out_vld), .set_idx(add_out_tag), .flags(ardy)
    );

    // The final write of the captured length ends the run.
    assign last_write = st_out_vld && (st_out_tag == IW'(len_q - 1'b1));

    // Port mapping.
    assign busy_o      = run;
    assign done_o      = done_q;
    assign cycles_o    = cycles_q;
    assign ld_issue_o  = ldx_issue || ldy_issue;
    assign ld_y_o      = ldy_issue;
    assign ld_idx_o    = ldy_issue ? ldy_idx : ldx_idx;
    assign ld_done_o   = ld_out_vld;
    assign mul_issue_o = mul_issue;
    assign mul_idx_o   = mul_idx;
    assign mul_done_o  = mul_out_vld;
    assign add_issue_o = add_issue;
    assign add_idx_o   = add_idx;
    assign add_done_o  = add_out_vld;
    assign st_issue_o  = st_issue;
    assign st_idx_o    = st_idx;
    assign st_done_o   = st_out_vld;

    // R1: an idle block raises no issue strobe.
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(ld_issue_o || mul_issue_o || add_issue_o || st_issue_o));

    // R10: the shared read pipe takes one element per cycle.
    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ldx_issue && ldy_issue));

    // R5: a product is started only on an X element already returned.
    p_mul_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mul_issue |-> xrdy[mul_idx]);

    // R5: a sum is started only when product and Y element are both ready.
    p_add_operands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        add_issue |-> (mrdy[add_idx] && yrdy[add_idx]));

    // R3: convoy-mode total equals the fixed formula.
    p_convoy_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !chain_q && (len_q != '0)) |->
        (cycles_o == CW'(CONVOY_BASE + 4 * int'(len_q))));

    // R6: chaining always beats the convoy total.
    p_chain_faster_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && chain_q && (len_q != '0)) |->
        (cycles_o < CW'(CONVOY_BASE + 4 * int'(len_q))));
endmodule

// File: tb/sim_vpt_chain_timer.sv
module sim_vpt_chain_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       chain_i = 1'b0;
    logic [3:0] vlen_i = '0;
    logic       busy_o, done_o, ld_issue_o, ld_y_o, ld_done_o;
    logic       mul_issue_o, mul_done_o, add_issue_o, add_done_o;
    logic       st_issue_o, st_done_o;
    logic [7:0] cycles_o;
    logic [2:0] ld_idx_o, mul_idx_o, add_idx_o, st_idx_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Recorded event times of the last run (-1 = not seen).
    int r_cnt, r_tdone, r_ldi, r_ldy, r_ldd, r_mi, r_md, r_ai, r_ad;
    int r_si, r_sd, r_lsd, r_nsd, r_niss, r_ndone;
    int uc [9];
    int ch [9];

    always #10 clk = ~clk;

    vpt_chain_timer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_i(chain_i),
        .vlen_i(vlen_i), .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o),
        .ld_issue_o(ld_issue_o), .ld_y_o(ld_y_o), .ld_idx_o(ld_idx_o),
        .ld_done_o(ld_done_o), .mul_issue_o(mul_issue_o), .mul_idx_o(mul_idx_o),
        .mul_done_o(mul_done_o), .add_issue_o(add_issue_o), .add_idx_o(add_idx_o),
        .add_done_o(add_done_o), .st_issue_o(st_issue_o), .st_idx_o(st_idx_o),
        .st_done_o(st_done_o)
    );

    // Table: {chain, length, expected count}.
    localparam logic [12:0] VEC [20] = '{
        {1'b0, 4'd0, 8'd0},  {1'b1, 4'd0, 8'd0},
        {1'b0, 4'd1, 8'd46}, {1'b1, 4'd1, 8'd40},
        {1'b0, 4'd2, 8'd50}, {1'b1, 4'd2, 8'd41},
        {1'b0, 4'd3, 8'd54}, {1'b1, 4'd3, 8'd42},
        {1'b0, 4'd4, 8'd58}, {1'b1, 4'd4, 8'd43},
        {1'b0, 4'd5, 8'd62}, {1'b1, 4'd5, 8'd44},
        {1'b0, 4'd6, 8'd66}, {1'b1, 4'd6, 8'd45},
        {1'b0, 4'd7, 8'd70}, {1'b1, 4'd7, 8'd46},
        {1'b0, 4'd8, 8'd74}, {1'b1, 4'd8, 8'd47},
        {1'b0, 4'd12, 8'd74}, {1'b1, 4'd15, 8'd47}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Launch one run and record event times relative to cycle 0.
    task automatic run_case(input bit c, input logic [3:0] n, input bit poke);
        int t;
        r_cnt = -1; r_tdone = -1; r_ldi = -1; r_ldy = -1; r_ldd = -1;
        r_mi = -1; r_md = -1; r_ai = -1; r_ad = -1; r_si = -1; r_sd = -1;
        r_lsd = -1; r_nsd = 0; r_niss = 0; r_ndone = 0;
        @(negedge clk);
        chain_i = c; vlen_i = n; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 0;
        while (t < 200) begin
            if (ld_issue_o && !ld_y_o && r_ldi < 0) r_ldi = t;
            if (ld_issue_o && ld_y_o && r_ldy < 0) r_ldy = t;
            if (ld_done_o && r_ldd < 0) r_ldd = t;
            if (mul_issue_o && r_mi < 0) r_mi = t;
            if (mul_done_o && r_md < 0) r_md = t;
            if (add_issue_o && r_ai < 0) r_ai = t;
            if (add_done_o && r_ad < 0) r_ad = t;
            if (st_issue_o && r_si < 0) r_si = t;
            if (st_done_o) begin
                if (r_sd < 0) r_sd = t;
                r_lsd = t;
                r_nsd++;
            end
            if (ld_issue_o || mul_issue_o || add_issue_o || st_issue_o) r_niss++;
            if (done_o) begin
                r_ndone++;
                if (r_tdone < 0) begin
                    r_tdone = t;
                    r_cnt = int'(cycles_o);
                end
            end
            if (poke && t == 4) begin
                start_i = 1'b1; vlen_i = 4'd8; chain_i = ~c;
            end
            if (poke && t == 5) start_i = 1'b0;
            if (r_tdone >= 0 && t > r_tdone + 20) break;
            @(negedge clk);
            t++;
        end
        vlen_i = n; chain_i = c;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && cycles_o == 0, "R1 reset outputs", int'(cycles_o), 0);
        chk(!(ld_issue_o || ld_done_o || mul_issue_o || mul_done_o || add_issue_o ||
              add_done_o || st_issue_o || st_done_o), "R1 strobes in reset", 1, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !ld_issue_o && !mul_issue_o, "R1 idle quiet", int'(busy_o), 0);

        // Table walk: R3, R5, R7, R8 totals.
        for (int i = 0; i < 20; i++) begin
            run_case(VEC[i][12], VEC[i][11:8], 1'b0);
            chk(r_cnt == int'(VEC[i][7:0]),
                VEC[i][11:8] == 0 ? "R7 zero length count" :
                (VEC[i][11:8] > 8 ? "R8 clamped length count" :
                (VEC[i][12] ? "R5 chained count" : "R3 convoy count")),
                r_cnt, int'(VEC[i][7:0]));
            if (VEC[i][11:8] == 0) begin
                chk(r_tdone == 0 && r_niss == 0, "R7 immediate done, no issue", r_tdone, 0);
            end else if (VEC[i][11:8] <= 8) begin
                if (VEC[i][12]) ch[VEC[i][11:8]] = r_cnt;
                else uc[VEC[i][11:8]] = r_cnt;
                chk(r_tdone == r_cnt + 1, "R3 done pulse timing", r_tdone, r_cnt + 1);
            end
        end

        // R6: chained faster for every legal length.
        for (int n = 1; n <= 8; n++) begin
            chk(ch[n] < uc[n], "R6 chained faster", ch[n], uc[n]);
        end

        // R4 and R2: convoy schedule with n = 3.
        run_case(1'b0, 4'd3, 1'b0);
        chk(r_ldi == 0, "R4 X read first issue", r_ldi, 0);
        chk(r_mi == 15, "R4 multiply first issue", r_mi, 15);
        chk(r_ldy == 16, "R4 Y read first issue", r_ldy, 16);
        chk(r_ai == 31, "R4 add first issue", r_ai, 31);
        chk(r_si == 40, "R4 write first issue", r_si, 40);
        chk(r_ldd - r_ldi == 12, "R2 read latency", r_ldd - r_ldi, 12);
        chk(r_md - r_mi == 7, "R2 multiply latency", r_md - r_mi, 7);
        chk(r_ad - r_ai == 6, "R2 add latency", r_ad - r_ai, 6);
        chk(r_sd - r_si == 12, "R2 write latency", r_sd - r_si, 12);
        chk(r_nsd == 3 && r_lsd - r_sd == 2, "R2 one write per cycle", r_nsd, 3);

        // R5 and R10: chained schedule with n = 3.
        run_case(1'b1, 4'd3, 1'b0);
        chk(r_mi == 13, "R5 chained multiply first issue", r_mi, 13);
        chk(r_ldy == 3, "R10 Y read right behind X", r_ldy, 3);
        chk(r_ai == 21, "R5 chained add first issue", r_ai, 21);
        chk(r_si == 28, "R5 chained write first issue", r_si, 28);

        // R9 and R11: start and input changes during a run are ignored.
        run_case(1'b0, 4'd2, 1'b1);
        chk(r_cnt == 50, "R9 R11 count unaffected by mid-run start", r_cnt, 50);
        chk(r_ndone == 1, "R9 no second run", r_ndone, 1);

        // R1: reset in the middle of a run returns to idle.
        @(negedge clk);
        chain_i = 1'b0; vlen_i = 4'd8; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy_o && cycles_o == 0 && !ld_done_o && !st_done_o,
            "R1 reset mid-run", int'(busy_o), 0);
        rst_n = 1'b1;
        run_case(1'b0, 4'd1, 1'b0);
        chk(r_cnt == 46, "R3 run after reset", r_cnt, 46);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule